// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Priority Controller

This block sits beside an 8051-style CPU core and decides which interrupt the core should take next. It collects ten individually vectored sources: two external pins, two timer overflows, a serial port, four further external pins and a watchdog. An eleventh request merges a group of peripheral flags into one shared auxiliary request. Each source is gated by its own enable and by a global enable. Each source has a priority bit that places it at the high or the low level. The auxiliary request bypasses the global enable and always sits at a third, fixed level above both.

The controller presents the vector address and level of the winning request whenever that level is strictly above the level of the handler now running. The core pulses an acknowledge when it vectors and a return strobe when a handler ends. A three-deep stack of active levels tracks nesting. On acknowledge, the controller clears the flags that clear by hardware: edge-mode external flags and timer overflow flags.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Vector addresses are fixed per source slot. Slots 0..4 (ext0, tmr0, ext1, tmr1, serial) map to 8*slot+03h, giving 03h, 0Bh, 13h, 1Bh and 23h. Slots 5..9 (ext2..ext5, watchdog) map to 43h+8*(slot-5), giving 43h, 4Bh, 53h, 5Bh and 63h. The auxiliary request uses 33h. Bit i of `src_en` and `src_high` belongs to slot i.
- R2: The auxiliary request is the OR of `aux_flag & aux_en`, gated by `aux_master_en`. It is not gated by `global_en`, and it always wins at level 3.
- R3: A slot requests only when its flag, its `src_en` bit and `global_en` are all 1.
- R4: Among slots, a set `src_high` bit gives level 2 and a clear bit gives level 1. Any pending level-2 slot beats every level-1 slot.
- R5: Within one level, the lowest slot number wins.
- R6: With `ext_edge_mode` set, a 1-then-0 on an `ext_pin_n` input over two consecutive clock samples sets the flag at that edge. The flag clears on an acknowledge that selects it, and a set in the same cycle wins. With the mode bit clear, the flag equals the inverted pin one cycle late and an acknowledge does not clear it.
- R7: A `tmr_ovf` pulse sets the timer flag at the next edge. An acknowledge that selects it clears the flag, and a set in the same cycle wins.
- R8: The serial request is `ser_rx_flag | ser_tx_flag`. An acknowledge clears neither flag.
- R9: `irq_req` is 1 only when the winning level is strictly above `active_level`. While `irq_req` is 0, `irq_vector` and `irq_level` read 0. `active_level` is 0 when no handler runs.
- R10: An acknowledge while `irq_req` is 1 and `irq_ret` is 0 pushes `irq_level` onto the level stack. An `irq_ret` pops one entry if the stack is not empty and takes precedence over an acknowledge in the same cycle. An acknowledge without `irq_req` has no effect.
- R11: After reset, all flags are 0, `active_level` is 0 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_flag | input | 7 | Peripheral flags forming the auxiliary group |
| aux_en | input | 7 | Per-flag enables of the auxiliary group |
| aux_master_en | input | 1 | Enable of the auxiliary request as a whole |
| ext_pin_n | input | 6 | Active-low external pins ext0..ext5 |
| ext_edge_mode | input | 6 | 1 = falling-edge mode, 0 = level mode, per pin |
| tmr_ovf | input | 2 | Timer overflow pulses, timer 0 and 1 |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| wdt_flag | input | 1 | Watchdog flag |
| src_en | input | 10 | Per-slot enables |
| global_en | input | 1 | Global enable of all slots |
| src_high | input | 10 | Per-slot priority: 1 = high |
| irq_ack | input | 1 | Core vectors to the presented request |
| irq_ret | input | 1 | Core returns from the running handler |
| irq_req | output | 1 | A request above the active level is presented |
| irq_vector | output | 8 | Vector address of the presented request |
| irq_level | output | 2 | Level of the presented request (1, 2 or 3) |
| active_level | output | 2 | Level of the running handler, 0 if none |
| ext_flag | output | 6 | External interrupt flags |
| tmr_flag | output | 2 | Timer overflow flags |

## Verification
Several properties are checked on every cycle. A presented request always sits strictly above the active level, and 33h always comes at level 3. The selection is never more than one slot and is high-level whenever level 2 wins. The stack never overflows and shrinks by one on every return. Timer and edge flags rise after their set events, and level-mode flags follow the pin. Only the bench's scenarios, checked against a cycle model, can show the rest: the exact vector table, the tie order, preemption and unwinding over a full three-deep nest, the serial flags surviving an acknowledge, and the set-wins-over-clear collisions.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int NUM_SRC = 10;
  localparam int NUM_EXT = 6;
  localparam int NUM_TMR = 2;
  localparam int IDX_W   = $clog2(NUM_SRC);

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_AUX  = 2'd3;

  localparam logic [7:0] AUX_VECTOR = 8'h33;
  localparam int SER_SLOT = 4;
  localparam int WDT_SLOT = 9;

  // Slot of external input k: ext0 -> 0, ext1 -> 2, ext2..5 -> 5..8
  function automatic int ext_slot(input int k);
    if (k == 0) return 0;
    if (k == 1) return 2;
    return k + 3;
  endfunction

  // Slot of timer t: tmr0 -> 1, tmr1 -> 3
  function automatic int tmr_slot(input int t);
    return 2 * t + 1;
  endfunction

  // Vector arithmetic: low bank 8*slot+3, upper bank 43h+8*(slot-5)
  function automatic logic [7:0] slot_vector(input logic [IDX_W-1:0] idx);
    logic [7:0] ofs;
    if (idx < IDX_W'(5)) begin
      ofs = {1'b0, idx, 3'b000};
      return ofs + 8'h03;
    end
    ofs = {1'b0, idx - IDX_W'(5), 3'b000};
    return ofs + 8'h43;
  endfunction

  // Isolate the lowest set bit of a request vector
  function automatic logic [NUM_SRC-1:0] lowest_bit(input logic [NUM_SRC-1:0] v);
    return v & (~v + NUM_SRC'(1));
  endfunction

endpackage

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_prio_pkg::*;
#(
  parameter int N_EXT = NUM_EXT,
  parameter int N_TMR = NUM_TMR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin_n,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic [N_EXT-1:0] ext_clr,
  input  logic [N_TMR-1:0] tmr_ovf,
  input  logic [N_TMR-1:0] tmr_clr,
  output logic [N_EXT-1:0] ext_flag,
  output logic [N_TMR-1:0] tmr_flag
);

  logic [N_EXT-1:0] pin_q;
  logic [N_EXT-1:0] fall_evt;

  assign fall_evt = ext_edge & pin_q & ~ext_pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= '1;
      ext_flag <= '0;
      tmr_flag <= '0;
    end else begin
      pin_q <= ext_pin_n;
      for (int k = 0; k < N_EXT; k++) begin
        if (ext_edge[k]) begin
          if (fall_evt[k])     ext_flag[k] <= 1'b1;
          else if (ext_clr[k]) ext_flag[k] <= 1'b0;
        end else begin
          ext_flag[k] <= ~ext_pin_n[k];
        end
      end
      for (int t = 0; t < N_TMR; t++) begin
        if (tmr_ovf[t])      tmr_flag[t] <= 1'b1;
        else if (tmr_clr[t]) tmr_flag[t] <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext_chk
    // R6: a sampled high-then-low in edge mode sets the flag
    assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_edge[k] && $past(ext_pin_n[k]) && !ext_pin_n[k]) |=> ext_flag[k]);
    // R6: level mode copies the inverted pin
    assert_level_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_edge[k] |=> (ext_flag[k] == !$past(ext_pin_n[k])));
  end

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr_chk
    // R7: overflow pulse sets the flag
    assert_tmr_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[t] |=> tmr_flag[t]);
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int N  = NUM_SRC,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_pend,
  input  logic [N-1:0]  src_high,
  input  logic          aux_pend,
  output logic          best_valid,
  output lvl_t          best_level,
  output logic [IW-1:0] best_idx,
  output logic          best_aux,
  output logic [N-1:0]  sel_onehot
);

  logic [N-1:0] hi_set;
  logic [N-1:0] cand;

  function automatic logic [IW-1:0] encode(input logic [N-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (oh[i]) r = IW'(i);
    return r;
  endfunction

  always_comb begin
    hi_set = src_pend & src_high;
    if (aux_pend)     cand = '0;
    else if (|hi_set) cand = hi_set;
    else              cand = src_pend;
    sel_onehot = lowest_bit(cand);
    best_idx   = encode(sel_onehot);
    best_aux   = aux_pend;
    if (aux_pend)       best_level = LVL_AUX;
    else if (|hi_set)   best_level = LVL_HIGH;
    else if (|src_pend) best_level = LVL_LOW;
    else                best_level = LVL_NONE;
    best_valid = (best_level != LVL_NONE);
  end

  // R5: at most one slot selected
  assert_single_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_onehot));
  // R4: a high-level win selects a high-priority slot
  assert_high_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (best_level == LVL_HIGH) |-> ((sel_onehot & src_high & src_pend) != '0));
  // R2: the auxiliary request masks every slot
  assert_aux_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    aux_pend |-> (sel_onehot == '0 && best_level == LVL_AUX));

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_prio_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  lvl_t          push_level,
  input  logic          pop,
  output lvl_t          active_level,
  output logic [DW-1:0] depth
);

  lvl_t stk [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= LVL_NONE;
    end else if (pop) begin
      if (depth != '0) depth <= depth - DW'(1);
    end else if (push && depth != DW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (DW'(i) == depth) stk[i] <= push_level;
      depth <= depth + DW'(1);
    end
  end

  always_comb begin
    active_level = LVL_NONE;
    for (int i = 0; i < DEPTH; i++)
      if (DW'(i + 1) == depth) active_level = stk[i];
  end

  // R10: depth never exceeds the stack size
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));
  // R9: only strictly higher levels are pushed
  assert_push_higher_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_level > active_level));
  // R10: a return on a non-empty stack removes one entry
  assert_pop_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && depth != '0) |=> (depth == $past(depth) - DW'(1)));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_AUX     = 7,
  parameter int STACK_DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_AUX-1:0] aux_flag,
  input  logic [NUM_AUX-1:0] aux_en,
  input  logic               aux_master_en,
  input  logic [NUM_EXT-1:0] ext_pin_n,
  input  logic [NUM_EXT-1:0] ext_edge_mode,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  input  logic               ser_rx_flag,
  input  logic               ser_tx_flag,
  input  logic               wdt_flag,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               global_en,
  input  logic [NUM_SRC-1:0] src_high,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               irq_req,
  output logic [7:0]         irq_vector,
  output logic [1:0]         irq_level,
  output logic [1:0]         active_level,
  output logic [NUM_EXT-1:0] ext_flag,
  output logic [NUM_TMR-1:0] tmr_flag
);

  localparam int SDW = $clog2(STACK_DEPTH + 1);

  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_pend;
  logic [NUM_SRC-1:0] sel_onehot;
  logic               aux_pend;
  logic               best_valid;
  lvl_t               best_level;
  logic [IDX_W-1:0]   best_idx;
  logic               best_aux;
  logic               take;
  logic [NUM_EXT-1:0] ext_clr;
  logic [NUM_TMR-1:0] tmr_clr;
  lvl_t               act_lvl;
  logic [SDW-1:0]     stk_depth;

  irq_flag_unit #(.N_EXT(NUM_EXT), .N_TMR(NUM_TMR)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ext_pin_n(ext_pin_n), .ext_edge(ext_edge_mode), .ext_clr(ext_clr),
    .tmr_ovf(tmr_ovf), .tmr_clr(tmr_clr),
    .ext_flag(ext_flag), .tmr_flag(tmr_flag)
  );

  always_comb begin
    src_raw = '0;
    for (int k = 0; k < NUM_EXT; k++) src_raw[ext_slot(k)] = ext_flag[k];
    for (int t = 0; t < NUM_TMR; t++) src_raw[tmr_slot(t)] = tmr_flag[t];
    src_raw[SER_SLOT] = ser_rx_flag | ser_tx_flag;
    src_raw[WDT_SLOT] = wdt_flag;
  end

  assign src_pend = src_raw & src_en & {NUM_SRC{global_en}};
  assign aux_pend = aux_master_en & (|(aux_flag & aux_en));

  irq_arbiter #(.N(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .src_pend(src_pend), .src_high(src_high), .aux_pend(aux_pend),
    .best_valid(best_valid), .best_level(best_level), .best_idx(best_idx),
    .best_aux(best_aux), .sel_onehot(sel_onehot)
  );

  irq_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(take), .push_level(best_level), .pop(irq_ret),
    .active_level(act_lvl), .depth(stk_depth)
  );

  assign irq_req      = best_valid && (best_level > act_lvl);
  assign take         = irq_ack & irq_req & ~irq_ret;
  assign active_level = act_lvl;
  assign irq_level    = irq_req ? best_level : LVL_NONE;
  assign irq_vector   = !irq_req ? 8'h00 : (best_aux ? AUX_VECTOR : slot_vector(best_idx));

  always_comb begin
    for (int k = 0; k < NUM_EXT; k++)
      ext_clr[k] = take & ~best_aux & sel_onehot[ext_slot(k)];
    for (int t = 0; t < NUM_TMR; t++)
      tmr_clr[t] = take & ~best_aux & sel_onehot[tmr_slot(t)];
  end

  // R9: a presented request outranks the running handler
  assert_req_above_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > active_level));
  // R2: the shared vector always comes at the top level
  assert_aux_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vector == AUX_VECTOR) |-> (irq_level == LVL_AUX));
  // R3: with the global enable off only the auxiliary path can request
  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!global_en && !aux_pend) |-> !irq_req);
  // R10: an acknowledge raises the active level to the taken level
  assert_push_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && stk_depth != SDW'(STACK_DEPTH)) |=> (active_level == $past(irq_level)));

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tclr
    // R7: taking a timer vector clears its flag unless re-set
    assert_tmr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_clr[t] && !tmr_ovf[t]) |=> !tmr_flag[t]);
  end

endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] aux_flag, aux_en;
  logic       aux_master_en;
  logic [5:0] ext_pin_n, ext_edge_mode;
  logic [1:0] tmr_ovf;
  logic       ser_rx_flag, ser_tx_flag, wdt_flag;
  logic [9:0] src_en, src_high;
  logic       global_en, irq_ack, irq_ret;
  logic       irq_req;
  logic [7:0] irq_vector;
  logic [1:0] irq_level, active_level;
  logic [5:0] ext_flag;
  logic [1:0] tmr_flag;

  irq_prio_ctrl u0 (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [5:0] m_ext, m_pinq;
  logic [1:0] m_tmr;
  logic [1:0] m_stk [3];
  int         m_depth;

  function automatic int b_ext_slot(int k);
    case (k) 0: return 0; 1: return 2; 2: return 5; 3: return 6; 4: return 7; default: return 8; endcase
  endfunction

  function automatic logic [7:0] b_vec(int s);
    case (s)
      0: return 8'h03; 1: return 8'h0B; 2: return 8'h13; 3: return 8'h1B; 4: return 8'h23;
      5: return 8'h43; 6: return 8'h4B; 7: return 8'h53; 8: return 8'h5B; default: return 8'h63;
    endcase
  endfunction

  function automatic void predict(output logic req, output logic [7:0] vec,
                                  output logic [1:0] lvl, output int idx, output logic aux);
    logic [9:0] raw, pend;
    logic [1:0] act;
    raw = '0;
    for (int k = 0; k < 6; k++) raw[b_ext_slot(k)] = m_ext[k];
    raw[1] = m_tmr[0]; raw[3] = m_tmr[1];
    raw[4] = ser_rx_flag | ser_tx_flag; raw[9] = wdt_flag;
    pend = raw & src_en & {10{global_en}};
    aux = aux_master_en && ((aux_flag & aux_en) != 0);
    idx = -1; lvl = 0;
    if (aux) lvl = 3;
    else begin
      for (int s = 0; s < 10; s++) if (pend[s] && src_high[s] && idx < 0) idx = s;
      if (idx >= 0) lvl = 2;
      else begin
        for (int s = 0; s < 10; s++) if (pend[s] && idx < 0) idx = s;
        if (idx >= 0) lvl = 1;
      end
    end
    act = (m_depth == 0) ? 2'd0 : m_stk[m_depth-1];
    req = (lvl > act);
    vec = !req ? 8'h00 : (aux ? 8'h33 : b_vec(idx));
    if (!req) lvl = 0;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag);
    logic req, aux, take; logic [7:0] vec; logic [1:0] lvl, act; int idx;
    #2;
    predict(req, vec, lvl, idx, aux);
    act = (m_depth == 0) ? 2'd0 : m_stk[m_depth-1];
    chk({tag, " R9"}, "irq_req", 8'(irq_req), 8'(req));
    chk({tag, " R1"}, "irq_vector", irq_vector, vec);
    chk({tag, " R4"}, "irq_level", 8'(irq_level), 8'(lvl));
    chk({tag, " R10"}, "active_level", 8'(active_level), 8'(act));
    chk({tag, " R6"}, "ext_flag", 8'(ext_flag), 8'(m_ext));
    chk({tag, " R7"}, "tmr_flag", 8'(tmr_flag), 8'(m_tmr));
    take = irq_ack && req && !irq_ret;
    @(posedge clk);
    for (int k = 0; k < 6; k++) begin
      if (ext_edge_mode[k]) begin
        if (m_pinq[k] && !ext_pin_n[k]) m_ext[k] = 1'b1;
        else if (take && !aux && idx == b_ext_slot(k)) m_ext[k] = 1'b0;
      end else m_ext[k] = !ext_pin_n[k];
    end
    m_pinq = ext_pin_n;
    for (int t = 0; t < 2; t++) begin
      if (tmr_ovf[t]) m_tmr[t] = 1'b1;
      else if (take && !aux && idx == 2*t+1) m_tmr[t] = 1'b0;
    end
    if (irq_ret) begin
      if (m_depth > 0) m_depth--;
    end else if (take && m_depth < 3) begin
      m_stk[m_depth] = lvl;
      m_depth++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    aux_flag = '0; aux_en = '1; aux_master_en = 1'b1;
    ext_pin_n = '1; ext_edge_mode = '0; tmr_ovf = '0;
    ser_rx_flag = 0; ser_tx_flag = 0; wdt_flag = 0;
    src_en = '1; src_high = '0; global_en = 1'b1; irq_ack = 0; irq_ret = 0;
    m_ext = '0; m_pinq = '1; m_tmr = '0; m_depth = 0;
    for (int i = 0; i < 3; i++) m_stk[i] = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic raise(int s);
    case (s)
      0: ext_pin_n[0] = 0; 2: ext_pin_n[1] = 0;
      5, 6, 7, 8: ext_pin_n[s-3] = 0;
      1: tmr_ovf[0] = 1; 3: tmr_ovf[1] = 1;
      4: ser_rx_flag = 1;
      default: wdt_flag = 1;
    endcase
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R11: reset state
    chk("R11", "irq_req", 8'(irq_req), 8'h00);
    chk("R11", "active_level", 8'(active_level), 8'h00);
    chk("R11", "flags", 8'({ext_flag, tmr_flag}), 8'h00);
    cycle("R11");

    // R1: every slot alone presents its vector
    for (int s = 0; s < 10; s++) begin
      do_reset();
      raise(s);
      cycle("R1");
      tmr_ovf = '0;
      cycle("R1");
      chk("R1", "vector table", irq_vector, b_vec(s));
    end

    // R2: auxiliary bypasses global enable, wins at level 3
    do_reset();
    global_en = 0; aux_flag = 7'b0001000; wdt_flag = 1; src_high = '1;
    cycle("R2");
    chk("R2", "aux vector", irq_vector, 8'h33);
    chk("R2", "aux level", 8'(irq_level), 8'h03);
    aux_en = 7'b1110111; cycle("R2");
    chk("R2", "aux gated by own enable", 8'(irq_req), 8'h00);
    aux_en = '1; aux_master_en = 0; cycle("R2");
    chk("R2", "aux gated by master", 8'(irq_req), 8'h00);

    // R3: per-slot and global enables
    do_reset();
    wdt_flag = 1; src_en = 10'h1FF; cycle("R3");
    chk("R3", "slot enable off", 8'(irq_req), 8'h00);
    src_en = '1; global_en = 0; cycle("R3");
    chk("R3", "global off", 8'(irq_req), 8'h00);
    global_en = 1; cycle("R3");
    chk("R3", "enabled", irq_vector, 8'h63);

    // R4/R5: high beats low, lowest slot wins a tie
    do_reset();
    ext_pin_n[0] = 0; wdt_flag = 1; cycle("R5"); cycle("R5");
    chk("R5", "tie order", irq_vector, 8'h03);
    src_high[9] = 1; cycle("R4");
    chk("R4", "high wins", irq_vector, 8'h63);

    // R6: edge flag set on fall, cleared on ack; level flag kept
    do_reset();
    ext_edge_mode[1] = 1; ext_pin_n[1] = 0; cycle("R6");
    chk("R6", "edge flag set", 8'(ext_flag[1]), 8'h01);
    irq_ack = 1; cycle("R6"); irq_ack = 0; irq_ret = 1; cycle("R6"); irq_ret = 0;
    cycle("R6");
    chk("R6", "edge flag cleared", 8'(ext_flag[1]), 8'h00);
    ext_pin_n[0] = 0; cycle("R6"); irq_ack = 1; cycle("R6"); irq_ack = 0; cycle("R6");
    chk("R6", "level flag kept", 8'(ext_flag[0]), 8'h01);

    // R9/R10: nesting three levels and unwinding
    do_reset();
    src_high[3] = 1; ext_pin_n[0] = 0; cycle("R9"); cycle("R9");
    irq_ack = 1; cycle("R10"); irq_ack = 0;
    chk("R10", "active low", 8'(active_level), 8'h01);
    ext_pin_n[1] = 0; cycle("R9"); cycle("R9");
    chk("R9", "equal level no preempt", 8'(irq_req), 8'h00);
    tmr_ovf[1] = 1; cycle("R7"); tmr_ovf[1] = 0; cycle("R9");
    chk("R9", "high preempts", irq_vector, 8'h1B);
    irq_ack = 1; cycle("R7"); irq_ack = 0; cycle("R7");
    chk("R7", "timer cleared", 8'(tmr_flag[1]), 8'h00);
    aux_flag = 7'b1000000; cycle("R10"); irq_ack = 1; irq_ret = 1; cycle("R10");
    chk("R10", "ret beats ack", 8'(active_level), 8'h01);
    irq_ret = 0; cycle("R10"); cycle("R10"); irq_ack = 0; aux_flag = '0;
    chk("R10", "active aux", 8'(active_level), 8'h03);
    irq_ret = 1; cycle("R10"); cycle("R10"); cycle("R10"); cycle("R10"); irq_ret = 0;
    chk("R10", "stack unwound", 8'(active_level), 8'h00);

    // R8: serial flags survive acknowledge
    do_reset();
    ser_tx_flag = 1; cycle("R8");
    chk("R8", "serial vector", irq_vector, 8'h23);
    irq_ack = 1; cycle("R8"); irq_ack = 0; irq_ret = 1; cycle("R8"); irq_ret = 0; cycle("R8");
    chk("R8", "serial still pending", irq_vector, 8'h23);

    // Random mix against the model
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      if (n % 200 == 0) begin
        ext_edge_mode = 6'($urandom); src_high = 10'($urandom);
        src_en = 10'($urandom) | 10'h155; aux_en = 7'($urandom);
      end
      global_en     = ($urandom % 8) != 0;
      aux_master_en = ($urandom % 4) != 0;
      aux_flag      = (($urandom % 10) == 0) ? 7'($urandom) : 7'h00;
      for (int k = 0; k < 6; k++) if (($urandom % 5) == 0) ext_pin_n[k] = ~ext_pin_n[k];
      tmr_ovf     = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
      ser_rx_flag = ($urandom % 9) == 0;
      ser_tx_flag = ($urandom % 11) == 0;
      wdt_flag    = ($urandom % 13) == 0;
      irq_ack     = ($urandom % 5) < 2;
      irq_ret     = ($urandom % 7) == 0;
      cycle("rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule